// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block sits beside the access scheduler of an SDRAM controller. It keeps the attached memory refreshed and moves it in and out of its two low-power states. A down-counter measures the refresh interval. Each time the interval runs out, a refresh is marked due. The sequencer then asks the access scheduler for the command bus, closes all banks and issues AUTO REFRESH.

Software drives three level inputs: a self-refresh request, a power-down request, and an enable for refreshing while powered down. Self-refresh takes precedence when both low-power requests are set. With the power-down refresh enable set, each due refresh briefly wakes the device from power-down, issues one AUTO REFRESH and puts it back. Recovery times after precharge, after refresh and after self-refresh exit come from input cycle counts. The current sequencer state is reported on a small encoded output.

Top module: `sdr_pm_seq`

## Requirements
- R1: After reset, CKE is high, the command bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111), bus_req is low and state_o reads 0 (idle).
- R2: A refresh becomes due every `refresh_interval` cycles (an interval of 0 acts as 1). Each due refresh, served from idle, produces PRECHARGE ALL (0010 with a10 high) followed by AUTO REFRESH (0001 with CKE high), so successive AUTO REFRESH commands from idle are exactly `refresh_interval` cycles apart.
- R3: Before driving PRECHARGE or AUTO REFRESH, the block raises bus_req and waits for bus_gnt. bus_req stays high during the whole sequence, including any low-power state, and falls only after the last recovery time has elapsed.
- R4: After PRECHARGE ALL, no further command or CKE change appears for at least `trp_cyc` cycles.
- R5: After AUTO REFRESH, no further command or CKE change appears, and bus_req does not fall, for at least `trfc_cyc` cycles.
- R6: When self-refresh and power-down are both requested, the block enters self-refresh (AUTO REFRESH with CKE falling in the same cycle). A self-refresh request that arrives during power-down makes the block leave power-down.
- R7: In self-refresh, CKE stays low and no refresh command is issued; refreshes falling due in that time are discarded. state_o reads 4.
- R8: Self-refresh ends when its request clears. CKE rises with NOP, and nothing else happens for at least `txsr_cyc` cycles. If power-down is still requested after that, the block enters power-down next.
- R9: Power-down is entered with NOP while CKE falls (state_o reads 6). It is left with CKE rising on NOP when its request clears.
- R10: While in power-down with `pwrdn_refresh_en` set, each due refresh causes, in order: CKE rising, one AUTO REFRESH, and CKE falling again with NOP.
- R11: `pwrdn_refresh_en` has no effect outside power-down. When it is clear, due refreshes do not wake the device from power-down.
- R12: Only one pending refresh is remembered. However many intervals expire while a refresh is held off, leaving power-down yields a single AUTO REFRESH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| selfref_req | input | 1 | Level request for self-refresh |
| pwrdn_req | input | 1 | Level request for power-down |
| pwrdn_refresh_en | input | 1 | Wake from power-down for each due refresh |
| refresh_interval | input | RATE_W | Cycles between due refreshes |
| trfc_cyc | input | T_W | Recovery cycles after AUTO REFRESH |
| trp_cyc | input | T_W | Recovery cycles after PRECHARGE ALL |
| txsr_cyc | input | T_W | Recovery cycles after self-refresh exit |
| bus_gnt | input | 1 | Command bus granted by access scheduler |
| bus_req | output | 1 | Command bus requested |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10 (high selects all banks on precharge) |
| cke | output | 1 | Clock enable to the memory |
| state_o | output | 3 | 0 idle, 1 await grant, 2 precharge wait, 3 refresh wait, 4 self-refresh, 5 self-refresh exit wait, 6 power-down, 7 power-down exit |

## Verification
The hardest case to reach from the ports is the interaction of the refresh timer with the low-power states. It takes a refresh that falls due during power-down while waking is disabled, several more intervals expiring on top of it, and then an exit that must produce exactly one refresh. The stimulus resets the block to align the timer, then places request edges at cycle counts chosen to sit between interval expiries. A refresh observed at the bus also serves as a sync point before power-down is requested. In this way self-refresh spans several intervals and power-down spans four intervals with waking disabled. A scoreboard of expected command events catches any extra, missing or reordered command, and measured gaps are compared against the recovery counts.

// File: rtl/sdr_pm_pkg.sv
package sdr_pm_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_PRE  = 3'd2,
    ST_RFC  = 3'd3,
    ST_SELF = 3'd4,
    ST_XS   = 3'd5,
    ST_PD   = 3'd6,
    ST_PDX  = 3'd7
  } pm_state_e;

  typedef enum logic [1:0] {
    EV_OTHER = 2'd0,
    EV_PRE   = 2'd1,
    EV_REF   = 2'd2,
    EV_SRX   = 2'd3
  } gap_kind_e;
endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] interval,
  input  logic              suppress,
  input  logic              consume,
  output logic              pending
);
  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] reload;
  logic              due;

  assign reload = (interval == '0) ? '0 : interval - 1'b1;
  assign due    = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= reload;
      pending <= 1'b0;
    end else begin
      cnt_q <= due ? reload : cnt_q - 1'b1;
      if (suppress)     pending <= 1'b0;
      else if (due)     pending <= 1'b1;
      else if (consume) pending <= 1'b0;
    end
  end

  // R12
  pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !consume && !suppress) |=> pending);

  // R7
  suppress_clear_chk: assert property (@(posedge clk) disable iff (rst)
    suppress |=> !pending);
endmodule

// File: rtl/sdr_wait_cnt.sv
module sdr_wait_cnt #(
  parameter int T_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [T_W-1:0] len,
  output logic           done
);
  logic [T_W-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (load)  cnt_q <= (len == '0) ? '0 : len - 1'b1;
    else if (!done) cnt_q <= cnt_q - 1'b1;
  end

  // R4
  short_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (load && len <= 1) |=> done);

  // R5
  long_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (load && len > 1) |=> !done);
endmodule

// File: rtl/sdr_pm_seq.sv
module sdr_pm_seq
  import sdr_pm_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int T_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selfref_req,
  input  logic              pwrdn_req,
  input  logic              pwrdn_refresh_en,
  input  logic [RATE_W-1:0] refresh_interval,
  input  logic [T_W-1:0]    trfc_cyc,
  input  logic [T_W-1:0]    trp_cyc,
  input  logic [T_W-1:0]    txsr_cyc,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              a10,
  output logic              cke,
  output logic [2:0]        state_o
);
  localparam int GAP_W = T_W + 1;

  pm_state_e      st_q, st_n;
  sdr_cmd_e       cmd_q, cmd_n;
  logic           a10_q, a10_n;
  logic           cke_q, cke_n;
  logic           req_q, req_n;
  logic           ld;
  logic [T_W-1:0] ld_len;
  logic           consume, go_dec;
  logic           ref_pend, wait_done;

  sdr_ref_timer #(.RATE_W(RATE_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .interval (refresh_interval),
    .suppress (st_q == ST_SELF),
    .consume  (consume),
    .pending  (ref_pend)
  );

  sdr_wait_cnt #(.T_W(T_W)) u_wait (
    .clk  (clk),
    .rst  (rst),
    .load (ld),
    .len  (ld_len),
    .done (wait_done)
  );

  always_comb begin
    st_n    = st_q;
    cmd_n   = CMD_NOP;
    a10_n   = 1'b0;
    cke_n   = cke_q;
    req_n   = req_q;
    ld      = 1'b0;
    ld_len  = '0;
    consume = 1'b0;
    go_dec  = 1'b0;
    case (st_q)
      ST_IDLE: if (selfref_req || pwrdn_req || ref_pend) begin
        req_n = 1'b1;
        st_n  = ST_REQ;
      end
      ST_REQ: if (bus_gnt) begin
        cmd_n  = CMD_PRE;
        a10_n  = 1'b1;
        ld     = 1'b1;
        ld_len = trp_cyc;
        st_n   = ST_PRE;
      end
      ST_PRE, ST_RFC, ST_XS: go_dec = wait_done;
      ST_SELF: if (!selfref_req) begin
        cke_n  = 1'b1;
        ld     = 1'b1;
        ld_len = txsr_cyc;
        st_n   = ST_XS;
      end
      ST_PD: if (selfref_req || !pwrdn_req || (pwrdn_refresh_en && ref_pend)) begin
        cke_n = 1'b1;
        st_n  = ST_PDX;
      end
      ST_PDX: go_dec = 1'b1;
      default: st_n = ST_IDLE;
    endcase
    if (go_dec) begin
      if (selfref_req) begin
        cmd_n   = CMD_REF;
        cke_n   = 1'b0;
        consume = 1'b1;
        st_n    = ST_SELF;
      end else if (ref_pend) begin
        cmd_n   = CMD_REF;
        consume = 1'b1;
        ld      = 1'b1;
        ld_len  = trfc_cyc;
        st_n    = ST_RFC;
      end else if (pwrdn_req) begin
        cke_n = 1'b0;
        st_n  = ST_PD;
      end else begin
        req_n = 1'b0;
        st_n  = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cmd_q <= CMD_NOP;
      a10_q <= 1'b0;
      cke_q <= 1'b1;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cmd_q <= cmd_n;
      a10_q <= a10_n;
      cke_q <= cke_n;
      req_q <= req_n;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign a10     = a10_q;
  assign cke     = cke_q;
  assign bus_req = req_q;
  assign state_o = st_q;

  // Gap tracking between command-bus or CKE events, for the recovery checks.
  logic            cke_prev;
  logic            ev;
  gap_kind_e       last_kind;
  logic [GAP_W-1:0] gap;

  assign ev = (cmd_q != CMD_NOP) || (cke_q != cke_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_prev  <= 1'b1;
      last_kind <= EV_OTHER;
      gap       <= '1;
    end else begin
      cke_prev <= cke_q;
      if (ev) begin
        gap <= GAP_W'(1);
        if (cmd_q == CMD_PRE)                last_kind <= EV_PRE;
        else if (cmd_q == CMD_REF && cke_q)  last_kind <= EV_REF;
        else if (cke_q && st_q == ST_XS)     last_kind <= EV_SRX;
        else                                 last_kind <= EV_OTHER;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R3
  cmd_needs_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |-> (req_q && $past(bus_gnt)));

  // R4
  trp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (ev && last_kind == EV_PRE) |-> (gap >= {1'b0, trp_cyc}));

  // R5
  trfc_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ((ev || $fell(req_q)) && last_kind == EV_REF) |-> (gap >= {1'b0, trfc_cyc}));

  // R8
  txsr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (ev && last_kind == EV_SRX) |-> (gap >= {1'b0, txsr_cyc}));

  // R7
  self_cke_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SELF) |-> (!cke_q && cmd_q != CMD_PRE));

  // R6
  sr_over_pd_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PD && selfref_req) |=> (st_q == ST_PDX && cke_q));

  // R10
  pd_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PD && pwrdn_refresh_en && ref_pend) |=> (st_q == ST_PDX));

  // R11
  pd_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PD && pwrdn_req && !selfref_req && !pwrdn_refresh_en) |=> (st_q == ST_PD && !cke_q));
endmodule

// File: tb/tb_sdr_pm_seq.sv
module tb_sdr_pm_seq;
  localparam int RATE_W = 16;
  localparam int T_W    = 5;
  localparam int E_PRE = 1, E_REF = 2, E_SRE = 3, E_SRX = 4, E_PDE = 5, E_PDX = 6, E_BAD = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic selfref_req = 0, pwrdn_req = 0, pwrdn_refresh_en = 0;
  logic [RATE_W-1:0] refresh_interval = 16'd60;
  logic [T_W-1:0] trfc_cyc = 5'd7, trp_cyc = 5'd3, txsr_cyc = 5'd9;
  logic bus_gnt = 0, gnt_d1 = 0;
  logic bus_req, cs_n, ras_n, cas_n, we_n, a10, cke;
  logic [2:0] state_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int exp_q[$];
  int ref_times[$];

  always #2 clk = ~clk;

  sdr_pm_seq #(.RATE_W(RATE_W), .T_W(T_W)) dut (
    .clk(clk), .rst(rst), .selfref_req(selfref_req), .pwrdn_req(pwrdn_req),
    .pwrdn_refresh_en(pwrdn_refresh_en), .refresh_interval(refresh_interval),
    .trfc_cyc(trfc_cyc), .trp_cyc(trp_cyc), .txsr_cyc(txsr_cyc), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .a10(a10), .cke(cke), .state_o(state_o));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push(input int e);
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // grant two cycles after request
  always @(negedge clk) begin
    gnt_d1  <= bus_req;
    bus_gnt <= gnt_d1;
  end

  // monitor / scoreboard
  bit prev_cke = 1'b1, prev_req = 1'b0, sr_mode = 1'b0;
  int last_kind = 0, last_cyc = 0;
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; prev_cke = 1'b1; prev_req = 1'b0; sr_mode = 1'b0; last_kind = 0; last_cyc = 0;
      ref_times.delete();
    end else begin
      int ev;
      logic [3:0] cmd;
      cyc++;
      cmd = {cs_n, ras_n, cas_n, we_n};
      ev = 0;
      if (cmd == 4'b0010 && a10)           ev = E_PRE;
      else if (cmd == 4'b0001)             ev = cke ? E_REF : E_SRE;
      else if (cmd != 4'b0111)             ev = E_BAD;
      else if (!cke && prev_cke)           ev = E_PDE;
      else if (cke && !prev_cke)           ev = sr_mode ? E_SRX : E_PDX;
      if (ev != 0) begin
        if (ev == E_PRE || ev == E_REF || ev == E_SRE)
          check(bus_req == 1'b1, "R3 command without bus", int'(bus_req), 1);
        if (last_kind == E_PRE) check(cyc - last_cyc >= int'(trp_cyc), "R4 precharge gap", cyc - last_cyc, int'(trp_cyc));
        if (last_kind == E_REF) check(cyc - last_cyc >= int'(trfc_cyc), "R5 refresh gap", cyc - last_cyc, int'(trfc_cyc));
        if (last_kind == E_SRX) check(cyc - last_cyc >= int'(txsr_cyc), "R8 self-refresh exit gap", cyc - last_cyc, int'(txsr_cyc));
        if (exp_q.size() == 0) check(1'b0, "R2/R12 unexpected event", ev, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(ev == e, "scoreboard event order (R2,R6,R9,R10)", ev, e);
        end
        if (ev == E_SRE) sr_mode = 1'b1;
        if (ev == E_SRX) sr_mode = 1'b0;
        if (ev == E_REF) ref_times.push_back(cyc);
        last_kind = ev; last_cyc = cyc;
      end
      if (prev_req && !bus_req && last_kind == E_REF)
        check(cyc - last_cyc >= int'(trfc_cyc), "R5 bus release after refresh", cyc - last_cyc, int'(trfc_cyc));
      prev_cke = cke; prev_req = bus_req;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    check(cke == 1'b1, "R1 cke", cke, 1);
    check(bus_req == 1'b0, "R1 bus_req", bus_req, 0);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 nop", {cs_n, ras_n, cas_n, we_n}, 7);
    check(state_o == 3'd0, "R1 state", state_o, 0);
    rst = 1'b0;

    // Phase A: interval 60; both low-power requests -> self-refresh (R6)
    wait_cyc(5);
    push(E_PRE); push(E_SRE);
    selfref_req = 1'b1; pwrdn_req = 1'b1;
    wait_cyc(145);
    check(cke == 1'b0, "R7 cke low in self-refresh", cke, 0);
    check(state_o == 3'd4, "R7 state self-refresh", state_o, 4);
    wait_cyc(160);   // ~310: several intervals expired in self-refresh, none issued (R7)
    push(E_SRX); push(E_PDE);
    selfref_req = 1'b0;   // R8 then power-down
    wait_cyc(20);
    check(state_o == 3'd6, "R9 state power-down", state_o, 6);
    check(cke == 1'b0, "R9 cke low in power-down", cke, 0);
    push(E_PDX);
    pwrdn_req = 1'b0;     // R9 exit
    wait_drain();
    wait_cyc(4);
    check(state_o == 3'd0 && bus_req == 1'b0, "R9 back to idle", state_o, 0);
    push(E_PRE); push(E_REF);   // refresh resumes after low-power (R2)
    wait_drain();
    wait_cyc(12);

    // Phase B: interval 50, power-down refresh enable set without power-down (R11)
    rst = 1'b1; refresh_interval = 16'd50; pwrdn_refresh_en = 1'b1;
    wait_cyc(3);
    exp_q.delete();
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin push(E_PRE); push(E_REF); end
    wait_drain();
    check(ref_times.size() == 3, "R2 refresh count", ref_times.size(), 3);
    if (ref_times.size() == 3) begin
      check(ref_times[1] - ref_times[0] == 50, "R2 refresh interval", ref_times[1] - ref_times[0], 50);
      check(ref_times[2] - ref_times[1] == 50, "R2 refresh interval", ref_times[2] - ref_times[1], 50);
    end
    while (bus_req) @(negedge clk);
    check(state_o == 3'd0, "R11 idle with enable set", state_o, 0);

    // R10: refreshes during power-down
    push(E_PRE); push(E_PDE);
    push(E_PDX); push(E_REF); push(E_PDE);
    push(E_PDX); push(E_REF); push(E_PDE);
    pwrdn_req = 1'b1;
    wait_drain();

    // R11/R12: enable cleared, four intervals pass in power-down
    pwrdn_refresh_en = 1'b0;
    wait_cyc(220);
    check(state_o == 3'd6 && cke == 1'b0, "R11 stays in power-down", state_o, 6);
    push(E_PDX); push(E_REF);
    pwrdn_req = 1'b0;
    wait_drain();
    push(E_PRE); push(E_REF);   // next refresh must come from idle, not a second held one (R12)
    wait_drain();
    wait_cyc(12);
    check(state_o == 3'd0 && bus_req == 1'b0, "R12 idle after single refresh", state_o, 0);
    check(exp_q.size() == 0, "scoreboard empty", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule